// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Front End

This block is the bus-facing half of a small serial EEPROM organised as two or four blocks of 256 bytes. It watches the two-wire bus lines (SCL and SDA) through a system-clock synchroniser. It recognises START and STOP conditions and deserialises the control byte, the word address and any data bytes. It answers each accepted byte by pulling SDA low through an open-drain output.

Write data leaves the block on a valid/ready stream toward a page buffer. The stream carries the full byte address and the data byte. A one-cycle commit pulse after STOP tells the write engine to start its internal cycle. While that engine reports busy, the slave stays silent and acknowledges nothing.

Reads are pointer based. The block presents its address pointer on `rd_addr_o`, takes the byte on `rd_data_i` and shifts it out MSB first. It advances the pointer after every byte. The system clock must run at least 16 times faster than SCL.

Back-pressure rule for the write stream: `wr_valid_o` rises one clock after the SCL edge that samples a byte's eighth bit. It stays high until `wr_ready_i` is seen high, or until SCL falls to open the acknowledge slot, whichever comes first. A byte that is still untaken when SCL falls is withdrawn and not acknowledged. A transfer happens on any clock where both signals are high.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) is honoured in any state, including a repeated START inside a transaction. It clears the bit count, and the next byte is decoded as a control byte. A STOP (SDA rising while SCL is high) returns the slave to idle.
- R2: A control byte is acknowledged only when its bits 7..4 equal 1010. For any other code, that byte and every later bit are left unanswered until the next START.
- R3: Control bit 0 selects the direction: 1 is a read, 0 is a write.
- R4: The block index is taken from control bits starting at bit 1, log2(NUM_BLOCKS) bits wide. Bit 3 is always ignored, and bit 2 is also ignored with two blocks. The index forms the pointer bits above bit 7.
- R5: In a write, the byte after the control byte is loaded into pointer bits 7..0 and is acknowledged.
- R6: Each later write byte is offered on the stream with `wr_addr_o` equal to the pointer. Once it is taken, only the low PAGE_BITS pointer bits increment, wrapping inside the page. The higher pointer bits stay unchanged.
- R7: A data byte not taken by the page buffer before SCL falls after its eighth bit is withdrawn and not acknowledged, and the transaction is dropped.
- R8: While `busy_i` is high at the acknowledge decision, no byte of any kind is acknowledged.
- R9: `commit_o` pulses for one clock after a STOP, if at least one data byte was taken since the previous STOP. Otherwise it stays low.
- R10: In a read, each byte is taken from `rd_data_i` at `rd_addr_o` and sent MSB first. The pointer then increments across the whole array, wrapping from the last address to zero.
- R11: After a read byte, an acknowledge from the master (SDA low) starts the next byte. A missing acknowledge leaves SDA released and the slave idle.
- R12: `sda_pull_o` changes only after SCL has been sampled low twice in a row, so it never changes while SCL is high. An acknowledge holds SDA low through the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| busy_i | input | 1 | Internal write cycle in progress |
| wr_valid_o | output | 1 | Write byte offered to the page buffer |
| wr_ready_i | input | 1 | Page buffer accepts the offered byte |
| wr_addr_o | output | 8+log2(NUM_BLOCKS) | Byte address of the offered write byte |
| wr_data_o | output | 8 | Offered write byte |
| rd_addr_o | output | 8+log2(NUM_BLOCKS) | Current pointer for read data |
| rd_data_i | input | 8 | Byte stored at `rd_addr_o` |
| commit_o | output | 1 | One-clock pulse: start the internal write cycle |

## Verification
The bench builds the slave with four blocks, a 16-byte page and two synchroniser stages. Four blocks make the middle select bit live, so block indices 1, 2 and 3 can each be reached. The read pointer can also wrap from the top of the fourth block back to address zero. The 16-byte page lets an 18-byte burst show the wrap of the low nibble while the upper pointer bits hold. SCL runs at 1/32 of the system clock, which keeps the two-sample output hold well inside each low phase.

// File: rtl/sesl_pkg.sv
`timescale 1ns/1ps
package sesl_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } sesl_state_e;

  typedef enum logic [1:0] {
    ROLE_CTRL,
    ROLE_ADDR,
    ROLE_DATA
  } sesl_role_e;
endpackage

// File: rtl/sesl_sampler.sv
`timescale 1ns/1ps
module sesl_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_low2,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic                   scl_prev;
  logic                   sda_prev;

  // bus idles high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_sync[SYNC_STAGES-1];
      sda_prev <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl  = scl_sync[SYNC_STAGES-1];
  assign sda_lvl  = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign scl_low2 = ~scl_lvl & ~scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/sesl_ptr.sv
`timescale 1ns/1ps
module sesl_ptr #(
  parameter  int BLK_BITS  = 1,
  parameter  int PAGE_BITS = 4,
  localparam int AW        = 8 + BLK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_blk,
  input  logic [BLK_BITS-1:0] blk_i,
  input  logic                set_low,
  input  logic [7:0]          low_i,
  input  logic                inc_page,
  input  logic                inc_seq,
  output logic [AW-1:0]       ptr_o
);
  localparam logic [PAGE_BITS-1:0] PG_ONE = PAGE_BITS'(1);
  localparam logic [AW-1:0]        AW_ONE = AW'(1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      if (set_blk) ptr_q[AW-1:8] <= blk_i;
      if (set_low) ptr_q[7:0] <= low_i;
      // page writes wrap inside the page, reads run across the whole array
      if (inc_page) ptr_q[PAGE_BITS-1:0] <= ptr_q[PAGE_BITS-1:0] + PG_ONE;
      if (inc_seq) ptr_q <= ptr_q + AW_ONE;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/serial_eeprom_slave.sv
`timescale 1ns/1ps
module serial_eeprom_slave
  import sesl_pkg::*;
#(
  parameter  int NUM_BLOCKS  = 2,
  parameter  int PAGE_BITS   = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int BLK_BITS    = $clog2(NUM_BLOCKS),
  localparam int AW          = 8 + BLK_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  input  logic          busy_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          commit_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, scl_low2, start_ev, stop_ev;

  sesl_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .scl_low2 (scl_low2),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sesl_state_e state_q;
  sesl_role_e  role_q;
  logic [3:0]  bit_q;
  logic [7:0]  rx_sr;
  logic [7:0]  tx_sr;
  logic        rw_q, ack_q, wr_valid_q, taken_q, wrote_q, commit_q, mack_q, pull_q;

  logic [7:0]    rx_next;
  logic          byte_end, handshake, byte_ok, pull_want;
  logic          set_blk, set_low, inc_page, inc_seq;
  logic [AW-1:0] ptr;
  logic          is_ctrl_role, in_rx_state;

  assign rx_next   = {rx_sr[6:0], sda_lvl};
  assign handshake = wr_valid_q & wr_ready_i;
  assign byte_end  = (state_q == ST_RX) && scl_fall && (bit_q == 4'd8);

  // acknowledge decision, taken on the falling SCL edge after bit eight
  always_comb begin
    unique case (role_q)
      ROLE_CTRL: byte_ok = (rx_sr[7:4] == DEV_CODE) && !busy_i;
      ROLE_ADDR: byte_ok = !busy_i;
      default:   byte_ok = !busy_i && (taken_q || handshake);
    endcase
  end

  assign set_blk  = byte_end && (role_q == ROLE_CTRL) && byte_ok;
  assign set_low  = byte_end && (role_q == ROLE_ADDR) && byte_ok;
  assign inc_page = byte_end && (role_q == ROLE_DATA) && byte_ok;
  assign inc_seq  = (state_q == ST_RACK) && scl_rise;

  sesl_ptr #(.BLK_BITS(BLK_BITS), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_blk  (set_blk),
    .blk_i    (rx_sr[1 +: BLK_BITS]),
    .set_low  (set_low),
    .low_i    (rx_sr),
    .inc_page (inc_page),
    .inc_seq  (inc_seq),
    .ptr_o    (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      role_q     <= ROLE_CTRL;
      bit_q      <= '0;
      rx_sr      <= '0;
      tx_sr      <= '1;
      rw_q       <= 1'b0;
      ack_q      <= 1'b0;
      wr_valid_q <= 1'b0;
      taken_q    <= 1'b0;
      wrote_q    <= 1'b0;
      commit_q   <= 1'b0;
      mack_q     <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (handshake) begin
        wr_valid_q <= 1'b0;
        taken_q    <= 1'b1;
        wrote_q    <= 1'b1;
      end
      if (start_ev) begin
        state_q    <= ST_RX;
        role_q     <= ROLE_CTRL;
        bit_q      <= '0;
        ack_q      <= 1'b0;
        wr_valid_q <= 1'b0;
        taken_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q    <= ST_IDLE;
        commit_q   <= wrote_q | handshake;
        wrote_q    <= 1'b0;
        ack_q      <= 1'b0;
        wr_valid_q <= 1'b0;
        taken_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise && bit_q != 4'd8) begin
              rx_sr <= rx_next;
              bit_q <= bit_q + 4'd1;
              if (bit_q == 4'd7 && role_q == ROLE_DATA && !busy_i) wr_valid_q <= 1'b1;
            end
            if (byte_end) begin
              ack_q      <= byte_ok;
              bit_q      <= '0;
              taken_q    <= 1'b0;
              wr_valid_q <= 1'b0;
              if (role_q == ROLE_CTRL) rw_q <= rx_sr[0];
              state_q <= byte_ok ? ST_ACK : ST_IDLE;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              bit_q <= '0;
              if (role_q == ROLE_CTRL && rw_q) begin
                state_q <= ST_TX;
                tx_sr   <= rd_data_i;
              end else begin
                state_q <= ST_RX;
                role_q  <= (role_q == ROLE_CTRL) ? ROLE_ADDR : ROLE_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_q == 4'd7) begin
                state_q <= ST_RACK;
              end else begin
                tx_sr <= {tx_sr[6:0], 1'b1};
                bit_q <= bit_q + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_lvl;
            if (scl_fall) begin
              bit_q <= '0;
              if (mack_q) begin
                state_q <= ST_TX;
                tx_sr   <= rd_data_i;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // output moves only once SCL has been low for two samples
  assign pull_want = ((state_q == ST_ACK) && ack_q) || ((state_q == ST_TX) && !tx_sr[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else if (scl_low2) pull_q <= pull_want;
  end

  assign is_ctrl_role = (role_q == ROLE_CTRL);
  assign in_rx_state  = (state_q == ST_RX);

  assign sda_pull_o = pull_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = ptr;
  assign wr_data_o  = rx_sr;
  assign rd_addr_o  = ptr;
  assign commit_o   = commit_q;
endmodule

// File: rtl/sesl_chk.sv
`timescale 1ns/1ps
module sesl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_pull,
  input logic       busy,
  input logic       ack_q,
  input logic       ctrl_role,
  input logic [3:0] rx_code,
  input logic       stop_ev,
  input logic       commit,
  input logic       wr_valid,
  input logic       in_rx
);
  AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull)); // R12

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !$past(busy)); // R8

  AST_CTRL_ACK_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && ctrl_role) |-> ($past(rx_code) == 4'b1010)); // R2

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_ev)); // R9

  AST_WR_VALID_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> in_rx); // R6
endmodule

bind serial_eeprom_slave sesl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .sda_pull  (sda_pull_o),
  .busy      (busy_i),
  .ack_q     (ack_q),
  .ctrl_role (is_ctrl_role),
  .rx_code   (rx_sr[7:4]),
  .stop_ev   (stop_ev),
  .commit    (commit_o),
  .wr_valid  (wr_valid_o),
  .in_rx     (in_rx_state)
);

// File: tb/serial_eeprom_slave_tb.sv
`timescale 1ns/1ps
module serial_eeprom_slave_tb;
  localparam int NB = 4;
  localparam int AW = 10;
  localparam int Q  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0, wr_ready = 1'b1;
  logic sda_pull, wr_valid, commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_bus;

  logic [7:0] mem [0:1023];
  assign rd_data = mem[rd_addr];
  assign sda_bus = sda_m & ~sda_pull;

  serial_eeprom_slave #(.NUM_BLOCKS(NB), .PAGE_BITS(4), .SYNC_STAGES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .busy_i     (busy),
    .wr_valid_o (wr_valid),
    .wr_ready_i (wr_ready),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .commit_o   (commit)
  );

  int checks = 0, errors = 0;
  int lg_n = 0, n_commit = 0, glitches = 0;
  logic [AW-1:0] lg_a [0:63];
  logic [7:0]    lg_d [0:63];
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  always @(posedge clk) begin
    if (wr_valid && wr_ready && lg_n < 64) begin
      lg_a[lg_n] <= wr_addr;
      lg_d[lg_n] <= wr_data;
      lg_n <= lg_n + 1;
    end
    if (commit) n_commit <= n_commit + 1;
    prev_scl  <= scl_m;
    prev_pull <= sda_pull;
    if (rst_n && scl_m && prev_scl && sda_pull !== prev_pull) glitches <= glitches + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
    end
    sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b1; tick(4*Q);
  endtask

  task automatic put_bit(input logic b);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_bus == 1'b0);
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(2*Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus};
      tick(Q); scl_m = 1'b0;
    end
    put_bit(!give_ack);
  endtask

  task automatic t_reset();
    chk("R12 pull released after reset", sda_pull, 0);
    chk("R6 no write offer after reset", wr_valid, 0);
    chk("R9 no commit after reset", commit, 0);
  endtask

  task automatic t_byte_write();
    logic a; int n0 = lg_n; int c0 = n_commit;
    bus_start();
    send_byte(8'hA4, a); chk("R2 control 1010 acked", a, 1);
    send_byte(8'h35, a); chk("R5 word address acked", a, 1);
    send_byte(8'h5A, a); chk("R6 data acked", a, 1);
    bus_stop();
    chk("R6 one byte offered", lg_n - n0, 1);
    chk("R4 block 2 address", lg_a[n0], 10'h235);
    chk("R6 data value", lg_d[n0], 8'h5A);
    chk("R9 commit after STOP", n_commit - c0, 1);
  endtask

  task automatic t_page_roll();
    logic a; int n0 = lg_n; int c0 = n_commit; int nack = 0;
    bus_start();
    send_byte(8'hA2, a); send_byte(8'h0E, a);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'h30 + 8'(k), a);
      if (!a) nack++;
    end
    bus_stop();
    chk("R6 all page bytes acked", nack, 0);
    chk("R6 page byte count", lg_n - n0, 18);
    for (int k = 0; k < 18; k++) begin
      chk("R6 page address wraps in nibble", lg_a[n0+k], 10'h100 | 10'((14 + k) % 16));
      chk("R6 page data", lg_d[n0+k], 8'h30 + 8'(k));
    end
    chk("R9 single commit per STOP", n_commit - c0, 1);
  endtask

  task automatic t_bad_code();
    logic a; int n0 = lg_n; int c0 = n_commit;
    bus_start();
    send_byte(8'hB0, a); chk("R2 wrong code not acked", a, 0);
    send_byte(8'h10, a); chk("R2 later byte ignored", a, 0);
    bus_stop();
    chk("R2 nothing offered", lg_n - n0, 0);
    chk("R9 no commit without data", n_commit - c0, 0);
  endtask

  task automatic t_block_msb_ignored();
    logic a; int n0 = lg_n;
    bus_start();
    send_byte(8'hAA, a); send_byte(8'h10, a); send_byte(8'hC3, a);
    bus_stop();
    chk("R4 bit 3 ignored, block 1", lg_a[n0], 10'h110);
  endtask

  task automatic t_backpressure();
    logic a; int n0 = lg_n; int c0 = n_commit;
    bus_start();
    send_byte(8'hA0, a); send_byte(8'h40, a);
    wr_ready = 1'b0;
    send_byte(8'h77, a);
    chk("R7 untaken byte not acked", a, 0);
    wr_ready = 1'b1;
    bus_stop();
    chk("R7 nothing transferred", lg_n - n0, 0);
    chk("R9 no commit after dropped byte", n_commit - c0, 0);
  endtask

  task automatic t_busy();
    logic a;
    busy = 1'b1;
    bus_start();
    send_byte(8'hA0, a); chk("R8 control not acked while busy", a, 0);
    send_byte(8'h10, a); chk("R8 silent after busy nack", a, 0);
    bus_stop();
    busy = 1'b0;
  endtask

  task automatic t_read();
    logic a; logic [7:0] d; int c0 = n_commit;
    bus_start();
    send_byte(8'hA6, a); send_byte(8'h20, a);
    bus_start();
    send_byte(8'hA7, a); chk("R1 repeated START decodes control", a, 1);
    recv_byte(d, 1'b1); chk("R3 R10 read byte 0", d, mem[10'h320]);
    recv_byte(d, 1'b1); chk("R10 read byte 1", d, mem[10'h321]);
    recv_byte(d, 1'b0); chk("R11 last byte before nack", d, mem[10'h322]);
    tick(Q);
    chk("R11 SDA released after nack", sda_pull, 0);
    bus_stop();
    chk("R9 no commit after read", n_commit - c0, 0);
  endtask

  task automatic t_read_wrap();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hA6, a); send_byte(8'hFF, a);
    bus_start();
    send_byte(8'hA7, a);
    recv_byte(d, 1'b1); chk("R10 top address", d, mem[10'h3FF]);
    recv_byte(d, 1'b0); chk("R10 pointer wraps to zero", d, mem[10'h000]);
    bus_stop();
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_byte_write();
    t_page_roll();
    t_bad_code();
    t_block_msb_ignored();
    t_backpressure();
    t_busy();
    t_read();
    t_read_wrap();
    chk("R12 pull never changed while SCL high", glitches, 0);
    finish_sim();
  end
endmodule